// File: doc/BRIEF.md
# Sector Write-Protection Checker

This block rules on whether a modify or erase request may touch the storage array. The array is split into 64 KB sectors. Two protection sources are merged for each sector. The first is a three-bit block-protect code that shields a run of sectors counted down from the top of the address space. The second is a small file of volatile per-sector lock registers. Each lock register holds a write-lock bit and a lock-down bit. Once lock-down is set, that sector's register is frozen until the next reset.

A command decoder hands over requests on a valid/ready channel and receives a one-bit verdict on a second valid/ready channel. The verdict register holds one response. A new request is accepted only when that register is empty or is being drained in the same cycle, so `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the verdict holds steady and no request is taken. The lock registers have a plain write strobe and a combinational read port. The block-protect code is a plain input that comes from the status register.

Top module: `wp_sector_guard`

## Requirements
- R1: The target sector of a request is `req_addr[20:16]`. Address bits 15..0 have no effect on the verdict.
- R2: The block-protect code `bp` shields sectors as follows: 0 shields none; 1 shields sector 31; 2 shields 30..31; 3 shields 28..31; 4 shields 24..31; 5 shields 16..31; 6 and 7 shield every sector. A shielded sector yields deny.
- R3: Bulk erase (op code 5) is allowed exactly when `bp` is 0. Lock registers play no part in this decision.
- R4: Op codes 0 (page program), 1 (page write), 2 (page erase), 3 (subsector erase) and 4 (sector erase) are denied when the write-lock bit of their target sector is 1.
- R5: A request with op code 0..4 is allowed only when neither the block-protect code nor the sector's write-lock covers its sector.
- R6: A lock write to sector `lk_wsel` with `lk_we` high loads `lk_wdata[0]` into the write-lock bit and `lk_wdata[1]` into the lock-down bit. The new value is visible from the next cycle.
- R7: While a sector's lock-down bit is 1, lock writes to that sector leave both of its bits unchanged.
- R8: Reset clears every lock bit and empties the verdict register.
- R9: `lk_rdata` equals {6'b0, lock-down, write-lock} of sector `lk_rsel`. It is combinational.
- R10: A request accepted at a clock edge produces `rsp_valid` high after that edge. `req_ready = !rsp_valid || rsp_ready`. A held verdict does not change.
- R11: The reserved op codes 6 and 7 are always denied.
- R12: The verdict uses the lock and `bp` values present before the accepting edge. A lock write in the same cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp | input | 3 | Block-protect code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_op | input | 3 | Request type code |
| req_addr | input | 21 | Request byte address |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Verdict consumed |
| rsp_allow | output | 1 | 1 = allow, 0 = deny |
| lk_we | input | 1 | Lock register write strobe |
| lk_wsel | input | 5 | Sector to write |
| lk_wdata | input | 2 | {lock-down, write-lock} |
| lk_rsel | input | 5 | Sector to read |
| lk_rdata | output | 8 | Lock register read value |

## Verification
Every verdict is due exactly one clock edge after its handshake. `req_ready` and `lk_rdata` are due in the same cycle as the inputs that drive them. The bench keeps a behavioural model that is advanced on each rising edge from the same input values the design sees. It compares all outputs at the falling edge that follows, so every result is checked at the cycle in which it falls due. Each modelled verdict carries the requirement tag of the request that produced it. A lock write issued together with a request therefore checks the old-state rule. A random phase toggles `rsp_ready` to exercise the hold behaviour.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_PWRITE  = 3'd1,
    OP_PERASE  = 3'd2,
    OP_SSERASE = 3'd3,
    OP_SERASE  = 3'd4,
    OP_BULK    = 3'd5
  } wp_op_e;

  localparam int LK_RD_W = 8;
endpackage

// File: rtl/wp_bp_decode.sv
module wp_bp_decode #(
  parameter int NUM_SECT = 32
) (
  input  logic [2:0]          bp,
  output logic [NUM_SECT-1:0] prot_mask
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    always_comb begin
      int span;
      span = 0;
      if (bp >= 3'd6)       span = NUM_SECT;
      else if (bp != 3'd0)  span = 1 << (int'(bp) - 1);
      prot_mask[s] = (s >= NUM_SECT - span);
    end
  end

  // covers: R2 - an all-clear code shields nothing
  always_comb begin
    if (bp == 3'd0) assert (prot_mask == '0);
  end
endmodule

// File: rtl/wp_lock_file.sv
module wp_lock_file #(
  parameter int NUM_SECT = 32,
  parameter int SEL_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      wsel,
  input  logic [1:0]            wdata,
  input  logic [SEL_W-1:0]      rsel,
  output logic [NUM_SECT-1:0]   wl_vec,
  output logic [NUM_SECT-1:0]   ld_vec,
  output logic [wp_pkg::LK_RD_W-1:0] rdata
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_reg
    logic hit;
    assign hit = we && (wsel == SEL_W'(s)) && !ld_vec[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wl_vec[s] <= 1'b0;
        ld_vec[s] <= 1'b0;
      end else if (hit) begin
        wl_vec[s] <= wdata[0];
        ld_vec[s] <= wdata[1];
      end
    end

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vec[s] |=> ld_vec[s] && $stable(wl_vec[s]));
  end

  assign rdata = {{(wp_pkg::LK_RD_W-2){1'b0}}, ld_vec[rsel], wl_vec[rsel]};

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !ld_vec[wsel]) |=> wl_vec[$past(wsel)] == $past(wdata[0]));
endmodule

// File: rtl/wp_sector_guard.sv
module wp_sector_guard #(
  parameter int ADDR_W   = 21,
  parameter int SECT_LSB = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  bp,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [2:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_allow,
  input  logic                        lk_we,
  input  logic [ADDR_W-SECT_LSB-1:0]  lk_wsel,
  input  logic [1:0]                  lk_wdata,
  input  logic [ADDR_W-SECT_LSB-1:0]  lk_rsel,
  output logic [7:0]                  lk_rdata
);
  import wp_pkg::*;
  localparam int SEL_W    = ADDR_W - SECT_LSB;
  localparam int NUM_SECT = 1 << SEL_W;

  logic [NUM_SECT-1:0] prot_mask, wl_vec, ld_vec;
  logic [SEL_W-1:0]    sect;
  logic                acc, verdict;
  wp_op_e              op;

  wp_bp_decode #(.NUM_SECT(NUM_SECT)) u_dec (.bp(bp), .prot_mask(prot_mask));

  wp_lock_file #(.NUM_SECT(NUM_SECT), .SEL_W(SEL_W)) u_locks (
    .clk(clk), .rst_n(rst_n), .we(lk_we), .wsel(lk_wsel), .wdata(lk_wdata),
    .rsel(lk_rsel), .wl_vec(wl_vec), .ld_vec(ld_vec), .rdata(lk_rdata));

  assign sect      = req_addr[ADDR_W-1:SECT_LSB];
  assign op        = wp_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  always_comb begin
    unique case (op)
      OP_PROG, OP_PWRITE, OP_PERASE, OP_SSERASE, OP_SERASE:
        verdict = !prot_mask[sect] && !wl_vec[sect];
      OP_BULK: verdict = (bp == 3'd0);
      default: verdict = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_allow <= verdict;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_allow));
  p_resp_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_bulk_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd5 && bp != 3'd0) |=> !rsp_allow);
  p_lock_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op < 3'd5 && wl_vec[sect]) |=> !rsp_allow);
  p_bp_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op < 3'd5 && prot_mask[sect]) |=> !rsp_allow);
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op > 3'd5) |=> !rsp_allow);
endmodule

// File: tb/wp_sector_guard_test.sv
module wp_sector_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bp = '0, req_op = '0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, lk_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [4:0] lk_wsel = '0, lk_rsel = '0;
  logic [1:0] lk_wdata = '0;
  wire req_ready, rsp_valid, rsp_allow;
  wire [7:0] lk_rdata;

  wp_sector_guard uut (.clk(clk), .rst_n(rst_n), .bp(bp), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .lk_we(lk_we), .lk_wsel(lk_wsel),
    .lk_wdata(lk_wdata), .lk_rsel(lk_rsel), .lk_rdata(lk_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit cmp_on = 0;
  string cur_tag = "R5";

  // behavioural reference
  bit m_wl[32], m_ld[32];
  bit m_rv, m_ra;
  string m_rtag;

  function automatic bit ref_allow(int op, int addr, int code);
    int sct, top_n;
    sct = (addr >> 16) & 31;
    if (op == 5) return code == 0;
    if (op > 5) return 0;
    case (code)
      0: top_n = 0;   1: top_n = 1;  2: top_n = 2;  3: top_n = 4;
      4: top_n = 8;   5: top_n = 16; default: top_n = 32;
    endcase
    if (sct >= 32 - top_n) return 0;
    return !m_wl[sct];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_wl[i]) begin m_wl[i] = 0; m_ld[i] = 0; end
      m_rv = 0;
    end else begin
      bit acc;
      acc = req_valid && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        m_rv = 1;
        m_ra = ref_allow(int'(req_op), int'(req_addr), int'(bp));
        m_rtag = cur_tag;
      end
      if (lk_we && !m_ld[lk_wsel]) begin
        m_wl[lk_wsel] = lk_wdata[0];
        m_ld[lk_wsel] = lk_wdata[1];
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (cmp_on) begin
      chk("R10 req_ready", req_ready, int'(!m_rv || rsp_ready));
      chk("R10 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk(m_rtag, rsp_allow, m_ra);
      chk("R9 lk_rdata", lk_rdata, {m_ld[lk_rsel], m_wl[lk_rsel]});
    end
  endtask

  task automatic req(int op, int addr);
    req_op = op[2:0]; req_addr = addr[20:0]; req_valid = 1'b1;
    lk_rsel = addr[20:16];
    tick();
    req_valid = 1'b0;
  endtask

  task automatic lkw(int s, int d);
    lk_we = 1'b1; lk_wsel = s[4:0]; lk_wdata = d[1:0]; lk_rsel = s[4:0];
    tick();
    lk_we = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sects[10] = '{0, 15, 16, 23, 24, 27, 28, 29, 30, 31};
    bit [15:0] lf = 16'hACE1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R8 reset rsp_valid", rsp_valid, 0);
    chk("R8 reset lk_rdata", lk_rdata, 0);
    cmp_on = 1;

    cur_tag = "R2";
    for (int c = 0; c < 8; c++) begin
      bp = c[2:0];
      foreach (sects[k]) req(0, (sects[k] << 16) | 16'h1234);
    end
    cur_tag = "R1"; bp = 3'd1;
    req(1, 21'h1FFFFF); req(1, 21'h1F0000); req(1, 21'h0EFFFF); req(1, 21'h1EFFFF);
    cur_tag = "R3";
    for (int c = 0; c < 8; c++) begin bp = c[2:0]; req(5, 21'h0); end

    bp = 3'd0;
    lkw(3, 1); lkw(9, 1);
    cur_tag = "R4";
    for (int op = 0; op < 5; op++) begin
      req(op, (3 << 16) | 16'h0100); req(op, 9 << 16); req(op, 10 << 16);
    end
    cur_tag = "R3"; req(5, 0);
    cur_tag = "R5"; bp = 3'd5; req(2, 3 << 16); req(2, 4 << 16); req(2, 20 << 16);
    bp = 3'd0;

    cur_tag = "R12";
    lk_we = 1'b1; lk_wsel = 5'd5; lk_wdata = 2'b01;
    req(0, 5 << 16); lk_we = 1'b0;
    req(0, 5 << 16);

    cur_tag = "R7";
    lkw(9, 3); lkw(9, 0); lkw(9, 2); req(0, 9 << 16);
    lkw(4, 2); lkw(4, 1); req(0, 4 << 16);
    cur_tag = "R6"; lkw(3, 0); req(0, 3 << 16);
    cur_tag = "R11"; req(6, 0); req(7, 1 << 16);

    cur_tag = "R10";
    for (int n = 0; n < 300; n++) begin
      bit sent;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rsp_ready = lf[0] | lf[5];
      if (!req_valid || sent) begin
        req_valid = lf[1];
        req_op = {1'b0, lf[3:2]} + {2'b0, lf[7]};
        req_addr = {lf[15:11], lf[10:0], 5'b0};
        bp = lf[9:7];
      end
      lk_we = lf[4] & lf[6]; lk_wsel = lf[12:8]; lk_wdata = lf[14:13];
      lk_rsel = lf[15:11];
      #1 sent = req_valid && req_ready;
      tick();
    end
    req_valid = 1'b0; lk_we = 1'b0; rsp_ready = 1'b1;
    tick();

    rst_n = 1'b0; tick(); cmp_on = 0; tick(); rst_n = 1'b1;
    cmp_on = 1;
    for (int s = 0; s < 32; s++) begin
      lk_rsel = s[4:0]; tick();
      chk("R8 lock cleared", lk_rdata, 0);
    end
    cur_tag = "R8"; bp = 3'd0; req(0, 9 << 16); tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule